// File: doc/BRIEF.md
# Debug Scan-Chain Router TAP

This block is a JTAG test access port that owns the chip's scan chain after reset. On its own it shows a 6-bit instruction register, a fixed identification code and a one-bit bypass path. A debugger first scans an 8-bit unlock key into a connect register. It can then use a 32-bit router-scan register to read and write a small register file. One register in that file drives the system-reset and keep-powered outputs. Another controls a secondary debug TAP.

When software sets the enable bit of the secondary TAP, the router does not splice that TAP in at once. It waits until the controller has spent a programmed number of TCK edges in Run-Test/Idle. After that, the secondary TAP sits between the router's serial output and the chip's TDO, so both the IR and the DR chain get longer. Any TCK edge spent in Test-Logic-Reset, and any assertion of TRST, removes the secondary TAP and clears every router setting. The chain then holds the router alone again. The secondary TAP modelled here supports bypass only.

Top module: `jrt_router_tap`

## Requirements
- R1: While trst_n is low, the controller is held in Test-Logic-Reset and tdo, sys_rst_o, keep_pwr_o and sec_sel_o are all 0.
- R2: Instruction register: it is 6 bits wide and is shifted LSB first. Capture-IR loads 6'b000001, so an IR scan of the router alone returns 0x01.
- R3: Identification: after reset the active instruction is IDCODE (0x04). It selects a 32-bit register that captures IDCODE_VAL (default 0x4B1D602F, bit 0 set).
- R4: Bypass: instruction 0x3F, and any code that is not 0x02, 0x04 or 0x07, selects a 1-bit register that captures 0. Data shifted through it comes out delayed by one bit.
- R5: Connect register: instruction 0x07 selects 8 bits. Update-DR with 0x89 sets the connected state, and any other value clears it. Capture returns 0x01 when connected and 0x00 otherwise.
- R6: Router scan: instruction 0x02 selects 32 bits. Bit 31 means write, bits 30:24 hold the address and bits 23:0 hold the data. When connected, Update-DR records the address and, on a write, stores the data into register 0x01 or 0x23 (other addresses hold nothing and read as 0). Capture returns {0, recorded address, that register's 24-bit value}.
- R7: Until connected, router-scan updates change no register and no output, and capture returns 0x80000000.
- R8: Register 0x01: bit 7 drives keep_pwr_o and bit 0 drives sys_rst_o. A write of 0x81000080 gives keep only, and a write of 0x81000081 gives keep plus system reset.
- R9: Register 0x23, bit 8 enables the secondary TAP. sec_sel_o rises on the IDLE_CLKS-th (default 10) rising TCK edge spent in Run-Test/Idle while the bit is set, and not before. A write that clears bit 8 drops sec_sel_o on that same update edge.
- R10: While sec_sel_o is 1, the secondary TAP (4-bit IR capturing 4'b0001, 1-bit bypass DR) sits between the router and tdo. A 10-bit IR scan returns 0x011, with the secondary bits shifted out first, and bypass data is delayed by two bits.
- R11: Any rising TCK edge in Test-Logic-Reset clears the connected state, both registers and the link. The instruction reverts to IDCODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data into the chain |
| tdo | output | 1 | Serial data out of the chain; 0 outside the Shift states |
| sys_rst_o | output | 1 | System reset request (register 0x01 bit 0) |
| keep_pwr_o | output | 1 | Keep-powered request (register 0x01 bit 7) |
| sec_sel_o | output | 1 | Secondary TAP linked into the chain |

## Verification
The properties assume that tms and tdi change only away from the rising TCK edge. They also assume that trst_n is released while TCK is low, so every state visit they reason about is a full TCK period. The bench meets this by driving tms and tdi on the falling edge and releasing reset there too, and by reading tdo one nanosecond later. The properties further assume that the enable bit only reaches the register through a router-scan write while connected. The bench's random writes keep that bit clear, so that linking happens only in the directed sequence with its counted idle clocks.

// File: rtl/jrt_pkg.sv
`timescale 1ns/1ps
package jrt_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_state_e;

  localparam int IR_W = 6;
  localparam int DR_W = 32;
  localparam int AD_W = 7;
  localparam int RD_W = 24;

  localparam logic [IR_W-1:0] OP_ROUTE   = 6'h02;
  localparam logic [IR_W-1:0] OP_IDCODE  = 6'h04;
  localparam logic [IR_W-1:0] OP_CONNECT = 6'h07;
  localparam logic [IR_W-1:0] OP_BYPASS  = 6'h3F;
  localparam logic [IR_W-1:0] IR_CAPTURE = 6'b000001;

  localparam logic [7:0]      CONNECT_KEY = 8'h89;
  localparam logic [AD_W-1:0] ADDR_CTRL   = 7'h01;
  localparam logic [AD_W-1:0] ADDR_SEC    = 7'h23;
  localparam int BIT_KEEP   = 7;
  localparam int BIT_SYSRST = 0;
  localparam int BIT_ENABLE = 8;

  function automatic tap_state_e next_state(tap_state_e s, logic tms);
    case (s)
      TS_RESET:    return tms ? TS_RESET   : TS_IDLE;
      TS_IDLE:     return tms ? TS_SEL_DR  : TS_IDLE;
      TS_SEL_DR:   return tms ? TS_SEL_IR  : TS_CAP_DR;
      TS_CAP_DR:   return tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: return tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: return tms ? TS_UPD_DR  : TS_PAUSE_DR;
      TS_PAUSE_DR: return tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: return tms ? TS_UPD_DR  : TS_SHIFT_DR;
      TS_UPD_DR:   return tms ? TS_SEL_DR  : TS_IDLE;
      TS_SEL_IR:   return tms ? TS_RESET   : TS_CAP_IR;
      TS_CAP_IR:   return tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: return tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: return tms ? TS_UPD_IR  : TS_PAUSE_IR;
      TS_PAUSE_IR: return tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: return tms ? TS_UPD_IR  : TS_SHIFT_IR;
      default:     return tms ? TS_SEL_DR  : TS_IDLE;
    endcase
  endfunction

  // Length of the data register an instruction selects
  function automatic logic [5:0] dr_len(logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE, OP_ROUTE: return 6'd32;
      OP_CONNECT:          return 6'd8;
      default:             return 6'd1;
    endcase
  endfunction

  // Shift one bit in at position len-1, LSB falls out
  function automatic logic [DR_W-1:0] shift_in(logic [DR_W-1:0] sr, logic b, logic [5:0] len);
    logic [DR_W-1:0] r;
    r = sr >> 1;
    r[5'(len - 6'd1)] = b;
    return r;
  endfunction

  function automatic logic            rs_write(logic [DR_W-1:0] w); return w[31];    endfunction
  function automatic logic [AD_W-1:0] rs_addr (logic [DR_W-1:0] w); return w[30:24]; endfunction
  function automatic logic [RD_W-1:0] rs_data (logic [DR_W-1:0] w); return w[23:0];  endfunction

endpackage

// File: rtl/jrt_tap_fsm.sv
`timescale 1ns/1ps
module jrt_tap_fsm
  import jrt_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= next_state(state, tms);
  end
endmodule

// File: rtl/jrt_route_regs.sv
`timescale 1ns/1ps
module jrt_route_regs
  import jrt_pkg::*;
#(
  parameter int IDLE_CLKS = 10
)(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            in_reset,
  input  logic            in_idle,
  input  logic            upd_connect,
  input  logic            upd_route,
  input  logic [DR_W-1:0] dr_word,
  output logic            connected,
  output logic            linked,
  output logic            sec_en,
  output logic            keep_pwr,
  output logic            sys_rst,
  output logic [DR_W-1:0] rd_word
);
  localparam int CW = $clog2(IDLE_CLKS + 1);

  logic [RD_W-1:0] ctrl_q, sec_q, sel_data;
  logic [AD_W-1:0] last_addr;
  logic [CW-1:0]   idle_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      connected <= 1'b0; ctrl_q <= '0; sec_q <= '0;
      last_addr <= '0;  linked <= 1'b0; idle_cnt <= '0;
    end else if (in_reset) begin
      connected <= 1'b0; ctrl_q <= '0; sec_q <= '0;
      last_addr <= '0;  linked <= 1'b0; idle_cnt <= '0;
    end else begin
      if (upd_connect) connected <= (dr_word[7:0] == CONNECT_KEY);
      // link qualification: count idle edges while enabled
      if (!sec_q[BIT_ENABLE]) begin
        linked   <= 1'b0;
        idle_cnt <= '0;
      end else if (!linked && in_idle) begin
        if (idle_cnt == CW'(IDLE_CLKS - 1)) linked <= 1'b1;
        idle_cnt <= idle_cnt + 1'b1;
      end
      if (upd_route && connected) begin
        last_addr <= rs_addr(dr_word);
        if (rs_write(dr_word)) begin
          if (rs_addr(dr_word) == ADDR_CTRL) ctrl_q <= rs_data(dr_word);
          if (rs_addr(dr_word) == ADDR_SEC) begin
            sec_q <= rs_data(dr_word);
            if (!dr_word[BIT_ENABLE]) begin
              linked   <= 1'b0;
              idle_cnt <= '0;
            end
          end
        end
      end
    end
  end

  always_comb begin
    if (last_addr == ADDR_CTRL)     sel_data = ctrl_q;
    else if (last_addr == ADDR_SEC) sel_data = sec_q;
    else                            sel_data = '0;
  end

  assign rd_word  = connected ? {1'b0, last_addr, sel_data} : {1'b1, {(DR_W-1){1'b0}}};
  assign sec_en   = sec_q[BIT_ENABLE];
  assign keep_pwr = ctrl_q[BIT_KEEP];
  assign sys_rst  = ctrl_q[BIT_SYSRST];
endmodule

// File: rtl/jrt_child_tap.sv
`timescale 1ns/1ps
module jrt_child_tap
  import jrt_pkg::*;
#(
  parameter int IRW = 4
)(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       hold,
  input  tap_state_e state,
  input  logic       si,
  output logic       so
);
  localparam logic [IRW-1:0] CAP = IRW'(1);

  logic [IRW-1:0] ir_sr;
  logic           bp;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= '0; bp <= 1'b0;
    end else if (hold) begin
      ir_sr <= '0; bp <= 1'b0;
    end else begin
      case (state)
        TS_CAP_IR:   ir_sr <= CAP;
        TS_SHIFT_IR: ir_sr <= {si, ir_sr[IRW-1:1]};
        TS_CAP_DR:   bp    <= 1'b0;
        TS_SHIFT_DR: bp    <= si;
        default: ;
      endcase
    end
  end

  assign so = (state == TS_SHIFT_IR) ? ir_sr[0] : bp;
endmodule

// File: rtl/jrt_router_tap.sv
`timescale 1ns/1ps
module jrt_router_tap
  import jrt_pkg::*;
#(
  parameter logic [31:0] IDCODE_VAL = 32'h4B1D_602F,
  parameter int          IDLE_CLKS  = 10,
  parameter int          CHILD_IR_W = 4
)(
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic sys_rst_o,
  output logic keep_pwr_o,
  output logic sec_sel_o
);
  tap_state_e      state;
  logic [IR_W-1:0] ir_sr, ir_q;
  logic [DR_W-1:0] dr_sr, cap_val, rd_word;
  logic            connected, linked, sec_en, router_so, child_so, shifting;
  logic            upd_connect, upd_route;

  jrt_tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= '0;
      ir_q  <= OP_IDCODE;
    end else begin
      case (state)
        TS_RESET:    ir_q  <= OP_IDCODE;
        TS_CAP_IR:   ir_sr <= IR_CAPTURE;
        TS_SHIFT_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        TS_UPD_IR:   ir_q  <= ir_sr;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ir_q)
      OP_IDCODE:  cap_val = IDCODE_VAL;
      OP_CONNECT: cap_val = {{(DR_W-1){1'b0}}, connected};
      OP_ROUTE:   cap_val = rd_word;
      default:    cap_val = '0;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) dr_sr <= '0;
    else if (state == TS_CAP_DR)   dr_sr <= cap_val;
    else if (state == TS_SHIFT_DR) dr_sr <= shift_in(dr_sr, tdi, dr_len(ir_q));
  end

  assign upd_connect = (state == TS_UPD_DR) && (ir_q == OP_CONNECT);
  assign upd_route   = (state == TS_UPD_DR) && (ir_q == OP_ROUTE);

  jrt_route_regs #(.IDLE_CLKS(IDLE_CLKS)) u_regs (
    .tck(tck), .trst_n(trst_n),
    .in_reset(state == TS_RESET), .in_idle(state == TS_IDLE),
    .upd_connect(upd_connect), .upd_route(upd_route), .dr_word(dr_sr),
    .connected(connected), .linked(linked), .sec_en(sec_en),
    .keep_pwr(keep_pwr_o), .sys_rst(sys_rst_o), .rd_word(rd_word)
  );

  assign shifting  = (state == TS_SHIFT_IR) || (state == TS_SHIFT_DR);
  assign router_so = (state == TS_SHIFT_IR) ? ir_sr[0] : dr_sr[0];

  jrt_child_tap #(.IRW(CHILD_IR_W)) u_child (
    .tck(tck), .trst_n(trst_n), .hold(!(linked && sec_en)),
    .state(state), .si(router_so), .so(child_so)
  );

  assign tdo       = shifting ? (linked ? child_so : router_so) : 1'b0;
  assign sec_sel_o = linked;
endmodule

// File: rtl/jrt_checker.sv
`timescale 1ns/1ps
module jrt_checker
  import jrt_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_sr,
  input logic            connected,
  input logic            sec_en,
  input logic            linked,
  input logic            keep_pwr,
  input logic            sys_rst
);
  AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n) (state == TS_CAP_IR) |=> (ir_sr == IR_CAPTURE)) else $error("ir capture"); // R2
  AST_LOCKED_REGS: assert property (@(posedge tck) disable iff (!trst_n) (!connected && state != TS_RESET) |=> $stable({keep_pwr, sys_rst, sec_en})) else $error("locked write"); // R7
  AST_LINK_FROM_IDLE: assert property (@(posedge tck) disable iff (!trst_n) $rose(linked) |-> ($past(state) == TS_IDLE)) else $error("link outside idle"); // R9
  AST_LINK_NEEDS_EN: assert property (@(posedge tck) disable iff (!trst_n) linked |-> sec_en) else $error("link without enable"); // R9
  AST_RESET_CLEARS: assert property (@(posedge tck) disable iff (!trst_n) (state == TS_RESET) |=> (!linked && !keep_pwr && !sys_rst && !connected)) else $error("reset state"); // R11
endmodule

bind jrt_router_tap jrt_checker u_chk (
  .tck(tck), .trst_n(trst_n), .state(state), .ir_sr(ir_sr),
  .connected(connected), .sec_en(sec_en), .linked(linked),
  .keep_pwr(keep_pwr_o), .sys_rst(sys_rst_o)
);

// File: tb/tb_jrt_router_tap.sv
`timescale 1ns/1ps
module tb_jrt_router_tap;
  localparam logic [31:0] IDV = 32'h4B1D_602F;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, sys_rst_o, keep_pwr_o, sec_sel_o;
  int   errs = 0, checks = 0;
  bit   done = 0;

  jrt_router_tap dut (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
                      .sys_rst_o(sys_rst_o), .keep_pwr_o(keep_pwr_o), .sec_sel_o(sec_sel_o));

  always #2.5 tck = ~tck;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o);
    @(negedge tck);
    tms = m; tdi = d;
    #1 o = tdo;
    @(posedge tck);
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, o);
  endtask

  // From Run-Test/Idle, scan n bits LSB first, return to Run-Test/Idle
  task automatic scan(input bit is_ir, input int n, input logic [63:0] val, output logic [63:0] cap);
    logic o;
    cap = '0;
    tick(1'b1, 1'b0, o);
    if (is_ir) tick(1'b1, 1'b0, o);
    tick(1'b0, 1'b0, o);
    tick(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, val[i], o);
      cap[i] = o;
    end
    tick(1'b1, 1'b0, o);
    tick(1'b0, 1'b0, o);
  endtask

  function automatic logic [63:0] rs_word(bit wr, logic [6:0] a, logic [23:0] d);
    return {32'd0, wr, a, d};
  endfunction

  function automatic logic [31:0] exp_rd(bit c, logic [6:0] a, logic [23:0] cr, logic [23:0] sr);
    logic [23:0] v;
    v = (a == 7'h01) ? cr : (a == 7'h23) ? sr : 24'd0;
    return c ? {1'b0, a, v} : 32'h8000_0000;
  endfunction

  function automatic logic [63:0] exp_delay(logic [7:0] d, int k);
    return 64'((d << k) & 8'hFF);
  endfunction

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog all-reqs actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] cap;
    logic [7:0]  key, d8;
    logic [6:0]  a, a2, last;
    logic [23:0] mctrl, msec, dat;
    bit          conn, nconn;
    logic        o;
    void'($urandom(32'd2024));

    repeat (3) @(posedge tck);
    #1;
    check("R1 outputs in reset", {60'd0, tdo, sys_rst_o, keep_pwr_o, sec_sel_o}, 64'd0);
    @(negedge tck); trst_n = 1'b1;
    tick(1'b0, 1'b0, o);

    scan(0, 32, 64'd0, cap);
    check("R3 idcode", cap, {32'd0, IDV});
    check("R3 idcode bit0", {63'd0, cap[0]}, 64'd1);

    scan(1, 6, 64'h3F, cap);
    check("R2 ir capture", cap, 64'h01);
    d8 = 8'hA5;
    scan(0, 8, {56'd0, d8}, cap);
    check("R4 bypass delay", cap, exp_delay(d8, 1));
    scan(1, 6, 64'h15, cap);
    check("R2 ir capture", cap, 64'h01);
    d8 = 8'h3C;
    scan(0, 8, {56'd0, d8}, cap);
    check("R4 undefined op bypass", cap, exp_delay(d8, 1));

    // not connected: writes ignored
    scan(1, 6, 64'h02, cap);
    scan(0, 32, rs_word(1, 7'h01, 24'h000081), cap);
    #1;
    check("R7 locked write keep/sys", {62'd0, keep_pwr_o, sys_rst_o}, 64'd0);
    scan(0, 32, rs_word(0, 7'h01, 24'd0), cap);
    check("R7 locked capture", cap, 64'h8000_0000);

    // connect key
    scan(1, 6, 64'h07, cap);
    scan(0, 8, 64'h88, cap);
    check("R5 connect capture before", cap, 64'h00);
    scan(0, 8, 64'h89, cap);
    check("R5 wrong key left unconnected", cap, 64'h00);
    scan(0, 8, 64'h89, cap);
    check("R5 key connects", cap, 64'h01);

    // random traffic against a model
    conn = 1; mctrl = '0; msec = '0; last = '0;
    for (int it = 0; it < 24; it++) begin
      key = ($urandom % 2) ? 8'h89 : 8'($urandom);
      if (($urandom % 2) == 0 && key == 8'h89) key = 8'h89;
      scan(1, 6, 64'h07, cap);
      check("R2 ir capture", cap, 64'h01);
      scan(0, 8, {56'd0, key}, cap);
      check("R5 connect capture", cap, {63'd0, conn});
      nconn = (key == 8'h89);
      conn = nconn;
      case ($urandom % 3)
        0: a = 7'h01;
        1: a = 7'h23;
        default: a = 7'($urandom);
      endcase
      dat = 24'($urandom);
      dat[8] = 1'b0;
      scan(1, 6, 64'h02, cap);
      scan(0, 32, rs_word(1, a, dat), cap);
      check("R6 capture before write", cap, {32'd0, exp_rd(conn, last, mctrl, msec)});
      if (conn) begin
        last = a;
        if (a == 7'h01) mctrl = dat;
        if (a == 7'h23) msec = dat;
      end
      #1;
      check(conn ? "R8 outputs after write" : "R7 outputs after locked write",
            {62'd0, keep_pwr_o, sys_rst_o}, {62'd0, mctrl[7], mctrl[0]});
      a2 = ($urandom % 2) ? 7'h01 : 7'h23;
      scan(0, 32, rs_word(0, a2, 24'd0), cap);
      check(conn ? "R6 readback" : "R7 locked readback", cap, {32'd0, exp_rd(conn, last, mctrl, msec)});
      if (conn) last = a2;
    end

    // directed bring-up sequence
    scan(1, 6, 64'h07, cap);
    scan(0, 8, 64'h89, cap);
    scan(1, 6, 64'h02, cap);
    scan(0, 32, 64'h8100_0080, cap);
    #1 check("R8 keep only", {62'd0, keep_pwr_o, sys_rst_o}, 64'b10);
    scan(0, 32, 64'hA300_2048, cap);
    #1 check("R9 no enable no link", {63'd0, sec_sel_o}, 64'd0);
    scan(0, 32, 64'h8100_0081, cap);
    #1 check("R8 keep and sysreset", {62'd0, keep_pwr_o, sys_rst_o}, 64'b11);
    scan(0, 32, 64'hA300_2148, cap);
    idle(9);
    #1 check("R9 not linked after 9 idle", {63'd0, sec_sel_o}, 64'd0);
    idle(1);
    #1 check("R9 linked after 10 idle", {63'd0, sec_sel_o}, 64'd1);

    scan(1, 10, 64'h3FF, cap);
    check("R10 chain ir capture", cap, 64'h011);
    d8 = 8'hB7;
    scan(0, 8, {56'd0, d8}, cap);
    check("R10 two-bit bypass", cap, exp_delay(d8, 2));

    // unlink by clearing enable: router IR gets 0x02, then 33-bit DR
    scan(1, 10, {54'd0, 6'h02, 4'hF}, cap);
    scan(0, 33, {31'd0, 32'hA300_2048, 1'b0}, cap);
    #1 check("R9 clear enable unlinks", {63'd0, sec_sel_o}, 64'd0);
    scan(1, 6, 64'h02, cap);
    check("R2 ir capture after unlink", cap, 64'h01);

    scan(0, 32, 64'hA300_2148, cap);
    idle(10);
    #1 check("R9 relinked", {63'd0, sec_sel_o}, 64'd1);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
    tick(1'b0, 1'b0, o);
    #1 check("R11 reset state clears outputs", {61'd0, sec_sel_o, keep_pwr_o, sys_rst_o}, 64'd0);
    scan(0, 32, 64'd0, cap);
    check("R11 idcode after reset state", cap, {32'd0, IDV});
    scan(1, 6, 64'h02, cap);
    check("R11 router alone ir", cap, 64'h01);
    scan(0, 32, rs_word(0, 7'h01, 24'd0), cap);
    check("R11 connect cleared", cap, 64'h8000_0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule